// File: doc/BRIEF.md
# Two-Wire Addressed Register Slave

This block is a slave on a two-wire serial bus (clock plus open-drain data) of the I2C kind. Its device address is six bits wide and comes from pins strapped on the board. Each bus transaction starts with an address byte. Two low bits in that byte choose the target and the direction. The target is either an internal pointer or a data port. The pointer selects one of 28 eight-bit registers. Data-port transfers use the register under the pointer, and the pointer steps forward by one after each data byte. A master can therefore fill or dump a run of consecutive registers in a single transaction. The whole register file is presented to the rest of the chip on one wide parallel output.

Both bus lines are synchronized into the system clock domain and oversampled there. The system clock must run well above the bus bit rate, which is nominally 100 kbit/s. The slave drives the data line only low, through an output-enable pin. The FSM has seven states: ST_IDLE, ST_ADDR (shift in the address byte), ST_AACK (acknowledge the address), ST_WR (shift in a written byte), ST_WACK (acknowledge it), ST_RD (shift out a byte) and ST_RACK (sample the master's acknowledge). A START moves any state to ST_ADDR and a STOP moves any state to ST_IDLE. All other transitions happen on a falling bus clock:

- ST_ADDR goes to ST_AACK after 8 bits when the address matches, and to ST_IDLE when it does not.
- ST_AACK goes to ST_RD for a read and to ST_WR for a write.
- ST_WR goes to ST_WACK after 8 bits, and ST_WACK returns to ST_WR.
- ST_RD goes to ST_RACK after 8 bits.
- ST_RACK returns to ST_RD when the master acknowledged, and goes to ST_IDLE when it did not.

Top module: `twreg_slave`

## Requirements
- R1: After reset every register reads 0, the pointer is 0 and the data line is released (sda_oe low).
- R2: The first byte after a START is sent MSB first. Bits [7:2] are the device address, bit 1 selects the target (0 pointer, 1 data port) and bit 0 is the direction (1 read). When bits [7:2] equal dev_addr, the slave pulls the data line low for the ninth clock.
- R3: When the address does not match, the slave gives no acknowledge and ignores the rest of the bus traffic until the next START. No register and no pointer value changes.
- R4: A written byte aimed at the pointer loads its low five bits into the pointer and is acknowledged. The upper three bits are dropped.
- R5: A written byte aimed at the data port is stored in the register under the pointer and acknowledged. The pointer then advances by one.
- R6: The pointer advances from 27 to 0, and from any value of 28 to 31 to 0. With the pointer at 28 to 31, data writes change nothing and data reads return 0.
- R7: A read aimed at the data port returns the selected register MSB first, and the pointer advances after each byte. A low acknowledge from the master continues the read with the next register. A high acknowledge ends the transaction and releases the line.
- R8: A read aimed at the pointer returns the pointer value in bits [4:0], with zeros above, and does not advance it.
- R9: The slave changes its data-line drive only while the synchronized bus clock is low.
- R10: A repeated START, with no STOP before it, abandons the current transfer and begins a new address byte.
- R11: Register k appears on regs_o[8k+7:8k].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, many times the bus bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen on the pin |
| sda_in | input | 1 | Bus data line as seen on the pin (wired-AND level) |
| dev_addr | input | 6 | Strapped device address |
| sda_oe | output | 1 | When high, the pad pulls the data line low |
| regs_o | output | 224 | All 28 registers in parallel, register k in bits [8k+7:8k] |

## Verification
The assertions assume that the master changes the data line only while the bus clock is low, except when it makes a START or a STOP. They also assume that each bus-clock phase lasts several system clocks, so an edge seen after the synchronizer still has a stable level one cycle later. The check that the slave moves its drive only during clock-low phases depends on that second assumption. The bench drives the bus through bit tasks that hold each phase for 24 system clocks and change the data line only at clock-low points. The one exception is the START and STOP tasks, which are built to produce exactly those line patterns.

// File: rtl/twreg_pkg.sv
package twreg_pkg;

    // Bus-protocol FSM states
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_WR,
        ST_WACK,
        ST_RD,
        ST_RACK
    } twreg_state_t;

endpackage

// File: rtl/twreg_sync.sv
module twreg_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] level,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);

    generate
        for (genvar b = 0; b < W; b++) begin : g_bit
            // chain[STAGES-1] is the synchronized level, chain[STAGES] its previous value
            logic [STAGES:0] chain;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '1;
                else        chain <= {chain[STAGES-1:0], din[b]};
            end

            assign level[b] = chain[STAGES-1];
            assign rise[b]  =  chain[STAGES-1] & ~chain[STAGES];
            assign fall[b]  = ~chain[STAGES-1] &  chain[STAGES];
        end
    endgenerate

endmodule

// File: rtl/twreg_ptr.sv
module twreg_ptr #(
    parameter int NREG = 28,
    parameter int PW   = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [PW-1:0] load_val,
    input  logic          inc,
    output logic [PW-1:0] ptr
);

    localparam logic [PW-1:0] LAST = PW'(NREG - 1);

    logic [PW-1:0] ptr_step;

    // Advance with wrap; any out-of-range value also returns to zero
    assign ptr_step = (ptr >= LAST) ? '0 : ptr + PW'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    ptr <= '0;
        else if (load) ptr <= load_val;
        else if (inc)  ptr <= ptr_step;
    end

endmodule

// File: rtl/twreg_regfile.sv
module twreg_regfile #(
    parameter int NREG = 28,
    parameter int DW   = 8,
    parameter int PW   = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [PW-1:0]    waddr,
    input  logic [DW-1:0]    wdata,
    input  logic [PW-1:0]    raddr,
    output logic [DW-1:0]    rdata,
    output logic [NREG*DW-1:0] regs_o
);

    generate
        for (genvar k = 0; k < NREG; k++) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    regs_o[k*DW +: DW] <= '0;
                else if (we && (waddr == PW'(k)))
                    regs_o[k*DW +: DW] <= wdata;
            end
        end
    endgenerate

    // Unmatched (nonexistent) addresses read as zero
    always_comb begin
        rdata = '0;
        for (int k = 0; k < NREG; k++) begin
            if (raddr == PW'(k)) rdata = regs_o[k*DW +: DW];
        end
    end

endmodule

// File: rtl/twreg_slave.sv
module twreg_slave #(
    parameter int NREG        = 28,
    parameter int DW          = 8,
    parameter int ADDR_W      = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 scl_in,
    input  logic                 sda_in,
    input  logic [ADDR_W-1:0]    dev_addr,
    output logic                 sda_oe,
    output logic [NREG*DW-1:0]   regs_o
);
    import twreg_pkg::*;

    localparam int PW = $clog2(NREG);
    localparam int BW = $clog2(DW + 1);
    localparam logic [BW-1:0] BYTE_BITS = BW'(DW);

    // Synchronized bus lines: bit 0 clock, bit 1 data
    logic [1:0] lvl, rse, fll;
    logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;

    twreg_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({sda_in, scl_in}),
        .level (lvl),
        .rise  (rse),
        .fall  (fll)
    );

    assign scl_s    = lvl[0];
    assign sda_s    = lvl[1];
    assign scl_rise = rse[0];
    assign scl_fall = fll[0];
    assign start_ev = scl_s & fll[1];
    assign stop_ev  = scl_s & rse[1];

    twreg_state_t state, state_nxt;
    logic [BW-1:0] bitcnt;
    logic [DW-1:0] rx, tx, rdata, rd_byte;
    logic          sel_data, rd_dir, m_ack;
    logic          byte_done, addr_hit;
    logic          wr_en, ptr_load, ptr_inc;
    logic [PW-1:0] ptr;

    assign byte_done = (bitcnt == BYTE_BITS);
    assign addr_hit  = (rx[DW-1 -: ADDR_W] == dev_addr);
    assign wr_en     = (state == ST_WR) && scl_fall && byte_done &&  sel_data;
    assign ptr_load  = (state == ST_WR) && scl_fall && byte_done && !sel_data;
    assign ptr_inc   = wr_en || ((state == ST_RD) && scl_fall && byte_done && sel_data);
    assign rd_byte   = sel_data ? rdata : DW'(ptr);

    twreg_ptr #(.NREG(NREG), .PW(PW)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ptr_load),
        .load_val (rx[PW-1:0]),
        .inc      (ptr_inc),
        .ptr      (ptr)
    );

    twreg_regfile #(.NREG(NREG), .DW(DW), .PW(PW)) u_rf (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (wr_en),
        .waddr  (ptr),
        .wdata  (rx),
        .raddr  (ptr),
        .rdata  (rdata),
        .regs_o (regs_o)
    );

    // Next-state logic
    always_comb begin
        state_nxt = state;
        if (start_ev) begin
            state_nxt = ST_ADDR;
        end else if (stop_ev) begin
            state_nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: state_nxt = ST_IDLE;
                ST_ADDR: if (scl_fall && byte_done)
                             state_nxt = addr_hit ? ST_AACK : ST_IDLE;
                ST_AACK: if (scl_fall)
                             state_nxt = rd_dir ? ST_RD : ST_WR;
                ST_WR:   if (scl_fall && byte_done) state_nxt = ST_WACK;
                ST_WACK: if (scl_fall) state_nxt = ST_WR;
                ST_RD:   if (scl_fall && byte_done) state_nxt = ST_RACK;
                ST_RACK: if (scl_fall)
                             state_nxt = m_ack ? ST_RD : ST_IDLE;
                default: state_nxt = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // Shift registers, bit counter and transaction flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt   <= '0;
            rx       <= '0;
            tx       <= '0;
            sel_data <= 1'b0;
            rd_dir   <= 1'b0;
            m_ack    <= 1'b0;
        end else if (start_ev) begin
            bitcnt <= '0;
        end else begin
            unique case (state)
                ST_ADDR, ST_WR: begin
                    if (scl_rise && !byte_done) begin
                        rx     <= {rx[DW-2:0], sda_s};
                        bitcnt <= bitcnt + BW'(1);
                    end
                    if ((state == ST_ADDR) && scl_fall && byte_done) begin
                        sel_data <= rx[1];
                        rd_dir   <= rx[0];
                    end
                end
                ST_AACK: begin
                    if (scl_fall) begin
                        bitcnt <= '0;
                        tx     <= rd_byte;
                    end
                end
                ST_WACK: begin
                    if (scl_fall) bitcnt <= '0;
                end
                ST_RD: begin
                    if (scl_rise && !byte_done) bitcnt <= bitcnt + BW'(1);
                    if (scl_fall && !byte_done) tx <= {tx[DW-2:0], 1'b0};
                end
                ST_RACK: begin
                    if (scl_rise) m_ack <= !sda_s;
                    if (scl_fall) begin
                        bitcnt <= '0;
                        tx     <= rd_byte;
                    end
                end
                default: ;
            endcase
        end
    end

    // Output decode: pull low for acknowledges and for zero data bits
    always_comb begin
        unique case (state)
            ST_AACK, ST_WACK: sda_oe = 1'b1;
            ST_RD:            sda_oe = !tx[DW-1];
            default:          sda_oe = 1'b0;
        endcase
    end

endmodule

// File: rtl/twreg_sva.sv
module twreg_sva
    import twreg_pkg::*;
#(
    parameter int NREG   = 28,
    parameter int DW     = 8,
    parameter int ADDR_W = 6,
    parameter int PW     = 5
) (
    input logic                clk,
    input logic                rst_n,
    input logic                scl_s,
    input logic                sda_oe,
    input twreg_state_t        state,
    input logic [DW-1:0]       rx,
    input logic [ADDR_W-1:0]   dev_addr,
    input logic [PW-1:0]       ptr,
    input logic                ptr_inc,
    input logic                ptr_load,
    input logic                wr_en,
    input logic [NREG*DW-1:0]  regs_o
);

    localparam logic [PW-1:0] LAST = PW'(NREG - 1);

    AST_OE_CLOCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_s); // R9

    AST_ACK_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_AACK) |-> (rx[DW-1 -: ADDR_W] == dev_addr)); // R2

    AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_inc && ptr >= LAST) |=> (ptr == '0)); // R6

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_inc && ptr < LAST) |=> (ptr == $past(ptr) + PW'(1))); // R5

    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ptr_inc && !ptr_load) |=> $stable(ptr)); // R8

    AST_REGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(regs_o)); // R3

    AST_WRITE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en); // R5

endmodule

bind twreg_slave twreg_sva #(
    .NREG(NREG), .DW(DW), .ADDR_W(ADDR_W), .PW(PW)
) u_sva (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (scl_s),
    .sda_oe   (sda_oe),
    .state    (state),
    .rx       (rx),
    .dev_addr (dev_addr),
    .ptr      (ptr),
    .ptr_inc  (ptr_inc),
    .ptr_load (ptr_load),
    .wr_en    (wr_en),
    .regs_o   (regs_o)
);

// File: tb/twreg_slave_bench.sv
module twreg_slave_bench;

    localparam int NREG = 28;
    localparam int H    = 24;
    localparam logic [5:0] DEV = 6'h2D;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic [NREG*8-1:0] regs_o;
    wire  sda_bus = sda_m & ~sda_oe;

    int n_chk = 0;
    int n_fail = 0;
    int n_viol = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    twreg_slave u_twreg_slave (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_in   (scl_m),
        .sda_in   (sda_bus),
        .dev_addr (DEV),
        .sda_oe   (sda_oe),
        .regs_o   (regs_o)
    );

    // R9 monitor: drive must not move while the bus clock is high
    logic prev_oe = 1'b0;
    always @(negedge clk) begin
        if (rst_n && scl_m && (sda_oe != prev_oe)) n_viol++;
        prev_oe <= sda_oe;
    end

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wt(H);
        scl_m = 1'b1; wt(H);
        sda_m = 1'b0; wt(H);
        scl_m = 1'b0; wt(H);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wt(H);
        scl_m = 1'b1; wt(H);
        sda_m = 1'b1; wt(H);
    endtask

    task automatic put_bit(input logic b);
        sda_m = b; wt(H);
        scl_m = 1'b1; wt(H);
        scl_m = 1'b0; wt(H);
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; wt(H);
        scl_m = 1'b1; wt(H / 2);
        b = sda_bus; wt(H / 2);
        scl_m = 1'b0; wt(H);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(b);
        ack = !b;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(!give_ack);
    endtask

    // Load the pointer in its own transaction
    task automatic set_ptr(input logic [7:0] p);
        logic a;
        bus_start();
        send_byte({DEV, 2'b00}, a); check("R2 address ack", 32'(a), 32'd1);
        send_byte(p, a);            check("R4 pointer byte ack", 32'(a), 32'd1);
        bus_stop();
    endtask

    task automatic read_ptr(output logic [7:0] v);
        logic a;
        bus_start();
        send_byte({DEV, 2'b01}, a);
        recv_byte(1'b0, v);
        bus_stop();
    endtask

    task automatic write_one(input logic [7:0] v);
        logic a;
        bus_start();
        send_byte({DEV, 2'b10}, a);
        send_byte(v, a); check("R5 data byte ack", 32'(a), 32'd1);
        bus_stop();
    endtask

    task automatic read_one(output logic [7:0] v);
        logic a;
        bus_start();
        send_byte({DEV, 2'b11}, a);
        recv_byte(1'b0, v);
        bus_stop();
    endtask

    // {index, value}: single write then single read back
    localparam logic [12:0] VEC [8] = '{
        {5'd0,  8'hA5}, {5'd1,  8'h3C}, {5'd13, 8'h81}, {5'd27, 8'hFF},
        {5'd14, 8'h00}, {5'd28, 8'h77}, {5'd31, 8'h5A}, {5'd20, 8'h69}
    };

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        logic [7:0] v2;
        logic a;
        logic [NREG*8-1:0] snap;

        wt(5);
        rst_n = 1'b1;
        wt(5);

        // R1 reset state
        check("R1 regs after reset", 32'(regs_o == '0), 32'd1);
        check("R1 line released", 32'(sda_oe), 32'd0);
        read_ptr(v);
        check("R1 pointer after reset", 32'(v), 32'd0);

        // Vector table: R5, R7, R11, R6
        for (int i = 0; i < 8; i++) begin
            logic [4:0] idx;
            logic [7:0] val;
            idx  = VEC[i][12:8];
            val  = VEC[i][7:0];
            snap = regs_o;
            set_ptr({3'b000, idx});
            write_one(val);
            set_ptr({3'b000, idx});
            read_one(v);
            if (idx < 5'(NREG)) begin
                check("R7 read back", 32'(v), 32'(val));
                check("R11 parallel slice", 32'(regs_o[idx*8 +: 8]), 32'(val));
            end else begin
                check("R6 out-of-range read", 32'(v), 32'd0);
                check("R6 out-of-range write ignored", 32'(regs_o == snap), 32'd1);
            end
        end

        // R4 upper pointer bits dropped
        set_ptr(8'hE3);
        read_ptr(v);
        check("R4 pointer low bits", 32'(v), 32'd3);

        // R3 wrong address ignored
        snap = regs_o;
        bus_start();
        send_byte({DEV ^ 6'h01, 2'b10}, a);
        check("R3 no ack on mismatch", 32'(a), 32'd0);
        send_byte(8'hEE, a);
        check("R3 later byte not acked", 32'(a), 32'd0);
        bus_stop();
        check("R3 regs unchanged", 32'(regs_o == snap), 32'd1);
        read_ptr(v);
        check("R3 pointer unchanged", 32'(v), 32'd3);

        // R6 burst write across the wrap
        set_ptr(8'd26);
        bus_start();
        send_byte({DEV, 2'b10}, a);
        send_byte(8'h11, a);
        send_byte(8'h22, a);
        send_byte(8'h33, a);
        bus_stop();
        check("R5 burst reg26", 32'(regs_o[26*8 +: 8]), 32'h11);
        check("R6 burst reg27", 32'(regs_o[27*8 +: 8]), 32'h22);
        check("R6 wrap to reg0", 32'(regs_o[7:0]), 32'h33);
        read_ptr(v);
        check("R6 pointer after wrap", 32'(v), 32'd1);
        read_ptr(v);
        check("R8 pointer read no advance", 32'(v), 32'd1);

        // R7 burst read with master ack then nack
        set_ptr(8'd26);
        bus_start();
        send_byte({DEV, 2'b11}, a);
        recv_byte(1'b1, v);  check("R7 burst byte0", 32'(v), 32'h11);
        recv_byte(1'b1, v);  check("R7 burst byte1", 32'(v), 32'h22);
        recv_byte(1'b0, v);  check("R7 burst byte2", 32'(v), 32'h33);
        check("R7 released after nack", 32'(sda_oe), 32'd0);
        bus_stop();
        read_ptr(v);
        check("R7 pointer advanced", 32'(v), 32'd1);

        // R10 repeated start between pointer load and read
        bus_start();
        send_byte({DEV, 2'b00}, a);
        send_byte(8'd13, a);
        bus_start();
        send_byte({DEV, 2'b11}, a);
        check("R10 ack after repeated start", 32'(a), 32'd1);
        recv_byte(1'b0, v2);
        bus_stop();
        check("R10 read after repeated start", 32'(v2), 32'h81);

        // R9 drive changes only with clock low
        check("R9 drive moved with clock high", 32'(n_viol), 32'd0);

        finish_run();
    end

endmodule